// File: doc/BRIEF.md
# CPU Interrupt Pending and Timer Controller

This block holds the pending state of eight CPU interrupt levels and decides when the core is to take an interrupt. External agents post or clear single levels by number, or wipe every level at once. A level number outside the legal range changes nothing and raises a one-cycle error flag.

An on-chip timer compares a free-running count with a compare value. When the two are equal and the count is not zero, it sets the pending bit of a line chosen by software. Writing the compare value acknowledges the timer by clearing that line.

A status register holds a global enable, an exception-level bit, an error-level bit and an 8-bit mask. These combine with the pending bits into a registered interrupt request. A separate output reports any pending level whatever the mask and gating. Software reaches count, compare, status and interrupt control through a small word-addressed register port.

Top module: `intr_ctrl`

## Requirements
- R1: After reset, pending bits, count and compare read 0. Status reads ie=0, exl=0, erl=1 and mask 0. Interrupt control reads line 7. irq_o, pend_o and lvl_err_o are 0.
- R2: A post of level n (0..7) sets ip_o[n] one cycle later and leaves the other pending bits unchanged.
- R3: A clear of level n (0..7) clears only ip_o[n]. When a post and a clear hit the same bit in one cycle, the bit ends up cleared.
- R4: A clear-all zeros all pending bits in the next cycle and overrides any post or timer set in the same cycle.
- R5: A post or clear with a level of 8..15 leaves ip_o unchanged and drives lvl_err_o high in the next cycle.
- R6: The count (address 0) increments by one on every cycle with cnt_en_i high. A register write to the count loads the written value instead.
- R7: While count equals compare (address 1) and count is nonzero, ip_o[line] is set on the following cycle. Here line is interrupt-control bits [2:0] (address 3). With count equal to compare at zero, nothing is set.
- R8: A write to the compare register clears ip_o[line] in the same cycle that the new compare value takes effect.
- R9: Status is address 2, with ie at bit 0, exl at bit 1, erl at bit 2 and the mask at bits [15:8]. One cycle after the register values, irq_o equals ie & !exl & !erl & |(mask & ip).
- R10: pend_o is high exactly when any pending bit is set, regardless of mask, enable or level bits.
- R11: reg_rdata_o returns, combinationally from reg_addr_i, the count, compare, status or interrupt-control register as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| post_i | input | 1 | Post the level on post_lvl_i |
| post_lvl_i | input | 4 | Level number to post |
| clr_i | input | 1 | Clear the level on clr_lvl_i |
| clr_lvl_i | input | 4 | Level number to clear |
| clr_all_i | input | 1 | Clear every pending level |
| cnt_en_i | input | 1 | Count increment enable |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address: 0 count, 1 compare, 2 status, 3 interrupt control |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data |
| ip_o | output | 8 | Pending bits |
| pend_o | output | 1 | Any level pending |
| irq_o | output | 1 | Registered interrupt request |
| lvl_err_o | output | 1 | Illegal level seen on the previous cycle |

## Verification
The assertions check on every cycle the properties that need a cycle or two of history:
- a legal post, uncontested by a clear, sets its bit;
- clear-all empties the pending field;
- an illegal lone post leaves the pending field alone;
- a timer match sets the selected line;
- an enabled count advances by one;
- a set enable-blocking bit suppresses the request.

Only the bench's scenarios show the rest:
- the exact bit patterns after sweeps over every legal and illegal level;
- same-cycle priority between post, clear and clear-all;
- the timer routed to each of the eight lines;
- the zero-count exclusion;
- the full gating truth table against several masks.

// File: rtl/intr_pkg.sv
package intr_pkg;
  localparam int unsigned ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADDR_COUNT = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_CMP   = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_STAT  = 2'd2;
  localparam logic [ADDR_W-1:0] ADDR_ICTL  = 2'd3;

  localparam int unsigned ST_IE    = 0;
  localparam int unsigned ST_EXL   = 1;
  localparam int unsigned ST_ERL   = 2;
  localparam int unsigned ST_IM_LO = 8;
endpackage

// File: rtl/intr_pending.sv
module intr_pending #(
  parameter int unsigned NUM_LVL = 8,
  parameter int unsigned LVL_W   = $clog2(NUM_LVL) + 1,
  parameter int unsigned LINE_W  = $clog2(NUM_LVL)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               post_i,
  input  logic [LVL_W-1:0]   post_lvl_i,
  input  logic               clr_i,
  input  logic [LVL_W-1:0]   clr_lvl_i,
  input  logic               clr_all_i,
  input  logic               tmr_set_i,
  input  logic               tmr_clr_i,
  input  logic [LINE_W-1:0]  tmr_line_i,
  output logic [NUM_LVL-1:0] ip_o,
  output logic               lvl_err_o
);
  logic [NUM_LVL-1:0] ip_q, ip_d, set_vec, clr_vec;
  logic post_ok, clr_ok, err_q;

  assign post_ok = post_i && (post_lvl_i < LVL_W'(NUM_LVL));
  assign clr_ok  = clr_i  && (clr_lvl_i  < LVL_W'(NUM_LVL));

  for (genvar g = 0; g < NUM_LVL; g++) begin : g_bit
    assign set_vec[g] = (post_ok && post_lvl_i == LVL_W'(g)) ||
                        (tmr_set_i && tmr_line_i == LINE_W'(g));
    assign clr_vec[g] = (clr_ok && clr_lvl_i == LVL_W'(g)) ||
                        (tmr_clr_i && tmr_line_i == LINE_W'(g));
  end

  // clear-all > single clear > set
  assign ip_d = clr_all_i ? '0 : ((ip_q | set_vec) & ~clr_vec);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ip_q  <= '0;
      err_q <= 1'b0;
    end else begin
      ip_q  <= ip_d;
      err_q <= (post_i && !post_ok) || (clr_i && !clr_ok);
    end
  end

  assign ip_o      = ip_q;
  assign lvl_err_o = err_q;

  assert_post_sets_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (post_i && post_lvl_i < LVL_W'(NUM_LVL) && !clr_all_i && !clr_i && !tmr_clr_i)
      |=> ip_q[$past(post_lvl_i[LINE_W-1:0])]);

  assert_clear_all_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_all_i |=> (ip_q == '0));

  assert_illegal_ignored_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (post_i && post_lvl_i >= LVL_W'(NUM_LVL) && !clr_i && !clr_all_i && !tmr_set_i && !tmr_clr_i)
      |=> (ip_q == $past(ip_q)) && lvl_err_o);
endmodule

// File: rtl/intr_timer.sv
module intr_timer #(
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cnt_en_i,
  input  logic          cnt_we_i,
  input  logic          cmp_we_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] cnt_o,
  output logic [DW-1:0] cmp_o,
  output logic          hit_o
);
  logic [DW-1:0] cnt_q, cmp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      cmp_q <= '0;
    end else begin
      if (cnt_we_i)      cnt_q <= wdata_i;
      else if (cnt_en_i) cnt_q <= cnt_q + DW'(1);
      if (cmp_we_i)      cmp_q <= wdata_i;
    end
  end

  assign hit_o = (cnt_q == cmp_q) && (cnt_q != '0);
  assign cnt_o = cnt_q;
  assign cmp_o = cmp_q;

  assert_count_step_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_en_i && !cnt_we_i) |=> (cnt_q == $past(cnt_q) + DW'(1)));

  assert_count_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cnt_en_i && !cnt_we_i) |=> $stable(cnt_q));
endmodule

// File: rtl/intr_regs.sv
module intr_regs
  import intr_pkg::*;
#(
  parameter int unsigned NUM_LVL = 8,
  parameter int unsigned DW      = 32,
  parameter int unsigned LINE_W  = $clog2(NUM_LVL)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               stat_we_i,
  input  logic               ictl_we_i,
  input  logic [DW-1:0]      wdata_i,
  output logic               ie_o,
  output logic               exl_o,
  output logic               erl_o,
  output logic [NUM_LVL-1:0] im_o,
  output logic [LINE_W-1:0]  line_o
);
  logic ie_q, exl_q, erl_q;
  logic [NUM_LVL-1:0] im_q;
  logic [LINE_W-1:0]  line_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ie_q   <= 1'b0;
      exl_q  <= 1'b0;
      erl_q  <= 1'b1;  // blocks requests until software clears it
      im_q   <= '0;
      line_q <= LINE_W'(NUM_LVL - 1);
    end else begin
      if (stat_we_i) begin
        ie_q  <= wdata_i[ST_IE];
        exl_q <= wdata_i[ST_EXL];
        erl_q <= wdata_i[ST_ERL];
        im_q  <= wdata_i[ST_IM_LO +: NUM_LVL];
      end
      if (ictl_we_i) line_q <= wdata_i[LINE_W-1:0];
    end
  end

  assign ie_o   = ie_q;
  assign exl_o  = exl_q;
  assign erl_o  = erl_q;
  assign im_o   = im_q;
  assign line_o = line_q;
endmodule

// File: rtl/intr_ctrl.sv
module intr_ctrl
  import intr_pkg::*;
#(
  parameter int unsigned NUM_LVL = 8,
  parameter int unsigned DW      = 32,
  parameter int unsigned LVL_W   = $clog2(NUM_LVL) + 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               post_i,
  input  logic [LVL_W-1:0]   post_lvl_i,
  input  logic               clr_i,
  input  logic [LVL_W-1:0]   clr_lvl_i,
  input  logic               clr_all_i,
  input  logic               cnt_en_i,
  input  logic               reg_we_i,
  input  logic [ADDR_W-1:0]  reg_addr_i,
  input  logic [DW-1:0]      reg_wdata_i,
  output logic [DW-1:0]      reg_rdata_o,
  output logic [NUM_LVL-1:0] ip_o,
  output logic               pend_o,
  output logic               irq_o,
  output logic               lvl_err_o
);
  localparam int unsigned LINE_W = $clog2(NUM_LVL);

  logic cnt_we, cmp_we, stat_we, ictl_we;
  logic [DW-1:0] cnt, cmp;
  logic tmr_hit, ie, exl, erl, irq_q;
  logic [NUM_LVL-1:0] im, ip;
  logic [LINE_W-1:0] line;

  assign cnt_we  = reg_we_i && reg_addr_i == ADDR_COUNT;
  assign cmp_we  = reg_we_i && reg_addr_i == ADDR_CMP;
  assign stat_we = reg_we_i && reg_addr_i == ADDR_STAT;
  assign ictl_we = reg_we_i && reg_addr_i == ADDR_ICTL;

  intr_timer #(.DW(DW)) i_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .cnt_en_i(cnt_en_i),
    .cnt_we_i(cnt_we), .cmp_we_i(cmp_we), .wdata_i(reg_wdata_i),
    .cnt_o(cnt), .cmp_o(cmp), .hit_o(tmr_hit)
  );

  intr_regs #(.NUM_LVL(NUM_LVL), .DW(DW), .LINE_W(LINE_W)) i_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .stat_we_i(stat_we), .ictl_we_i(ictl_we),
    .wdata_i(reg_wdata_i), .ie_o(ie), .exl_o(exl), .erl_o(erl),
    .im_o(im), .line_o(line)
  );

  intr_pending #(.NUM_LVL(NUM_LVL), .LVL_W(LVL_W), .LINE_W(LINE_W)) i_pending (
    .clk_i(clk_i), .rst_ni(rst_ni), .post_i(post_i), .post_lvl_i(post_lvl_i),
    .clr_i(clr_i), .clr_lvl_i(clr_lvl_i), .clr_all_i(clr_all_i),
    .tmr_set_i(tmr_hit), .tmr_clr_i(cmp_we), .tmr_line_i(line),
    .ip_o(ip), .lvl_err_o(lvl_err_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= ie && !exl && !erl && |(im & ip);
  end

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      ADDR_COUNT: reg_rdata_o = cnt;
      ADDR_CMP:   reg_rdata_o = cmp;
      ADDR_STAT: begin
        reg_rdata_o[ST_IE]  = ie;
        reg_rdata_o[ST_EXL] = exl;
        reg_rdata_o[ST_ERL] = erl;
        reg_rdata_o[ST_IM_LO +: NUM_LVL] = im;
      end
      default:    reg_rdata_o[LINE_W-1:0] = line;
    endcase
  end

  assign ip_o   = ip;
  assign pend_o = |ip;
  assign irq_o  = irq_q;

  assert_gate_blocks_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ie || exl || erl) |=> !irq_o);

  assert_masked_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((im & ip) == '0) |=> !irq_o);

  assert_timer_sets_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tmr_hit && !clr_all_i && !cmp_we && !clr_i) |=> ip_o[$past(line)]);

  assert_cmp_clears_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_we && !(post_i && post_lvl_i == LVL_W'(line))) |=> !ip_o[$past(line)]);
endmodule

// File: tb/test_intr_ctrl.sv
`timescale 1ns/1ps
module test_intr_ctrl;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        post_i = 1'b0, clr_i = 1'b0, clr_all_i = 1'b0, cnt_en_i = 1'b0;
  logic [3:0]  post_lvl_i = '0, clr_lvl_i = '0;
  logic        reg_we_i = 1'b0;
  logic [1:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic [7:0]  ip_o;
  logic        pend_o, irq_o, lvl_err_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  intr_ctrl i_intr_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .post_i(post_i), .post_lvl_i(post_lvl_i),
    .clr_i(clr_i), .clr_lvl_i(clr_lvl_i), .clr_all_i(clr_all_i),
    .cnt_en_i(cnt_en_i), .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i),
    .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o), .ip_o(ip_o),
    .pend_o(pend_o), .irq_o(irq_o), .lvl_err_o(lvl_err_o)
  );

  always #10 clk = ~clk;

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d cycles expected < 100000", cycles);
      finish_run();
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one edge applied, sampled at the following falling edge
  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    tick();
    reg_we_i = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] d);
    reg_addr_i = a; #1; d = reg_rdata_o;
  endtask

  task automatic post(logic [3:0] l);
    post_i = 1'b1; post_lvl_i = l; tick(); post_i = 1'b0;
  endtask

  task automatic clr(logic [3:0] l);
    clr_i = 1'b1; clr_lvl_i = l; tick(); clr_i = 1'b0;
  endtask

  task automatic clr_all();
    clr_all_i = 1'b1; tick(); clr_all_i = 1'b0;
  endtask

  initial begin
    logic [31:0] d;
    logic [7:0]  exp_ip;
    tick(); tick();
    rst_ni = 1'b1;
    tick();

    // R1 reset state
    rd(2'd0, d); check("R1 count", d, 0);
    rd(2'd1, d); check("R1 compare", d, 0);
    rd(2'd2, d); check("R1 status", d, 32'h4);
    rd(2'd3, d); check("R1 ictl", d, 7);
    check("R1 ip", {24'd0, ip_o}, 0);
    check("R1 irq/pend/err", {29'd0, irq_o, pend_o, lvl_err_o}, 0);

    // R2 single posts and accumulation
    for (int l = 0; l < 8; l++) begin
      clr_all();
      post(4'(l));
      check("R2 single post", {24'd0, ip_o}, 32'(1 << l));
      check("R10 pend single", {31'd0, pend_o}, 1);
    end
    clr_all();
    exp_ip = '0;
    for (int l = 7; l >= 0; l -= 2) begin
      post(4'(l)); exp_ip |= 8'(1 << l);
      check("R2 accumulate", {24'd0, ip_o}, {24'd0, exp_ip});
    end

    // R3 clears one bit at a time
    for (int l = 0; l < 8; l++) post(4'(l));
    exp_ip = 8'hff;
    for (int l = 0; l < 8; l++) begin
      clr(4'(l)); exp_ip &= ~8'(1 << l);
      check("R3 single clear", {24'd0, ip_o}, {24'd0, exp_ip});
    end
    check("R10 pend empty", {31'd0, pend_o}, 0);
    post_i = 1'b1; post_lvl_i = 4'd3; clr_i = 1'b1; clr_lvl_i = 4'd3; tick();
    post_i = 1'b0; clr_i = 1'b0;
    check("R3 clear beats post", {24'd0, ip_o}, 0);
    post_i = 1'b1; post_lvl_i = 4'd5; clr_i = 1'b1; clr_lvl_i = 4'd2; tick();
    post_i = 1'b0; clr_i = 1'b0;
    check("R3 post+clear other bit", {24'd0, ip_o}, 32'h20);

    // R4 clear-all beats post
    post(4'd1);
    post_i = 1'b1; post_lvl_i = 4'd6; clr_all_i = 1'b1; tick();
    post_i = 1'b0; clr_all_i = 1'b0;
    check("R4 clear-all", {24'd0, ip_o}, 0);

    // R5 illegal levels
    post(4'd0); post(4'd4);
    for (int l = 8; l < 16; l++) begin
      post(4'(l));
      check("R5 post ignored", {24'd0, ip_o}, 32'h11);
      check("R5 err post", {31'd0, lvl_err_o}, 1);
      clr(4'(l));
      check("R5 clear ignored", {24'd0, ip_o}, 32'h11);
      check("R5 err clear", {31'd0, lvl_err_o}, 1);
    end
    post(4'd2);
    check("R5 err drops", {31'd0, lvl_err_o}, 0);

    // R9 gating and mask sweep with ip = 0x0a
    clr_all(); post(4'd1); post(4'd3);
    for (int g = 0; g < 8; g++) begin
      for (int m = 0; m < 5; m++) begin
        logic [7:0] im;
        logic exp;
        im = (m == 0) ? 8'h00 : (m == 1) ? 8'h02 : (m == 2) ? 8'hf5 :
             (m == 3) ? 8'hff : 8'h08;
        wr(2'd2, {16'd0, im, 5'd0, 3'(g)});
        tick();
        exp = g[0] && !g[1] && !g[2] && ((im & 8'h0a) != 0);
        check("R9 irq gating", {31'd0, irq_o}, {31'd0, exp});
        if (g == 0 && m == 0)
          check("R10 pend ignores mask", {31'd0, pend_o}, 1);
      end
    end
    rd(2'd2, d); check("R11 status read", d, 32'h0807);
    wr(2'd2, 32'h0);

    // R7/R8 timer routed to each line (cnt_en off, compare 9)
    for (int t = 0; t < 8; t++) begin
      wr(2'd3, 32'(t));
      clr_all();
      wr(2'd1, 32'd9);
      wr(2'd0, 32'd9);
      check("R7 not before match edge", {24'd0, ip_o}, 0);
      tick();
      check("R7 timer line", {24'd0, ip_o}, 32'(1 << t));
      wr(2'd0, 32'd0);
      wr(2'd1, 32'd20);
      check("R8 compare write clears", {24'd0, ip_o}, 0);
    end
    rd(2'd3, d); check("R11 ictl read", d, 7);
    rd(2'd1, d); check("R11 compare read", d, 20);

    // R8 compare write clears only the timer line
    post(4'd7); post(4'd0);
    wr(2'd1, 32'd30);
    check("R8 only timer line", {24'd0, ip_o}, 32'h01);

    // R7 zero count never fires
    clr_all();
    wr(2'd1, 32'd0);
    tick(); tick();
    check("R7 zero count", {24'd0, ip_o}, 0);

    // R6 count enable and load
    wr(2'd1, 32'd500);
    wr(2'd0, 32'd100);
    cnt_en_i = 1'b1;
    for (int i = 0; i < 10; i++) tick();
    cnt_en_i = 1'b0;
    rd(2'd0, d); check("R6 increments", d, 110);
    tick();
    rd(2'd0, d); check("R6 holds", d, 110);
    cnt_en_i = 1'b1;
    wr(2'd0, 32'd40);
    cnt_en_i = 1'b0;
    rd(2'd0, d); check("R6 write wins", d, 40);

    // R7 match reached by counting
    wr(2'd1, 32'd105);
    wr(2'd0, 32'd100);
    cnt_en_i = 1'b1;
    for (int i = 0; i < 5; i++) tick();
    cnt_en_i = 1'b0;
    check("R7 before count match", {24'd0, ip_o}, 0);
    tick();
    check("R7 counted match", {24'd0, ip_o}, 32'h80);

    // R9 request raised end to end
    wr(2'd2, 32'h8001);
    tick();
    check("R9 irq on", {31'd0, irq_o}, 1);
    wr(2'd2, 32'h8005);
    tick();
    check("R9 erl blocks", {31'd0, irq_o}, 0);

    finish_run();
  end
endmodule